// File: doc/BRIEF.md
# Write Preamble Generator and Toggle Driver

This block sits at the channel-bit end of a disk write path. It runs on the channel-bit clock. When the write gate is seen active, it writes a 2T sync field: two channel bits of positive write current, then two of negative, over and over. The field's length is programmable in byte times, and each byte time is nine channel bits because the upstream code has rate 8/9. While the field is being written, the block checks that the controller's NRZ byte stays at zero and latches a sticky flag if it does not.

Once the field is complete, the block strobes a ready signal so the upstream encoder can start. From then on, each already-precoded channel bit drives a toggle flip-flop. The output of that flip-flop is the write-current polarity.

When the gate drops, the toggle flip-flop is forced to its zero state and a reduced-drive flag is raised. That flag tells the analog driver to lower its pull-down current while the write outputs stay enabled. A gate drop during the sync field aborts the field, and the next write starts the pattern from its beginning.

Top module: `wr_preamble_toggle`

## Requirements
- R1: While reset is held and after its release with the gate low, wr_pol=0, low_drive=1, data_ready=0 and sync_err=0.
- R2: The sync field starts one cycle after the first clock edge at which wr_gate is sampled 1 from idle. Its bit k (k=0 first) is shown on wr_pol, where 1 means positive write current, and equals 1 when bit 1 of k is 0 and 0 otherwise. This gives the sequence 1,1,0,0,1,1,0,0...
- R3: The sync field is L = 9 * max(len_bytes, 8) channel bits long. len_bytes is captured at the starting edge, and later changes to it do not alter the field in progress.
- R4: A len_bytes value below 8, including 0, gives a field of exactly 72 channel bits.
- R5: data_ready is 1 only during the cycle that shows sync bit L-1, and for exactly one cycle per write.
- R6: chan_bit is sampled at the edge that ends the data_ready cycle and at every later edge while the gate is active. A sampled 1 inverts wr_pol and a sampled 0 leaves it unchanged.
- R7: sync_err is set at any edge that samples a nonzero nrz_byte while sync bits 0..L-1 are being shown. It stays set until the starting edge of the next write clears it. A nonzero nrz_byte in the data phase or in idle has no effect on it.
- R8: After any edge that samples wr_gate=0, wr_pol=0 and data_ready=0. This holds in the middle of the sync field too, and the next write then restarts the field at bit 0.
- R9: low_drive is 1 after an edge that samples wr_gate=0 and 0 after an edge that samples wr_gate=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Channel-bit clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_gate | input | 1 | Write gate, active high |
| len_bytes | input | LEN_W | Requested sync field length in byte times |
| nrz_byte | input | 8 | Controller NRZ byte, which must be zero during the sync field |
| chan_bit | input | 1 | Encoded, precoded channel bit for the data phase |
| wr_pol | output | 1 | Toggle flip-flop output, the write-current polarity |
| low_drive | output | 1 | Reduced pull-down drive request while the gate is inactive |
| data_ready | output | 1 | One-cycle strobe on the last sync bit |
| sync_err | output | 1 | Sticky flag for a nonzero NRZ byte during the sync field |

## Verification
The bench walks every bit of the sync field against a 2T sequence it computes itself. It does this for a normal length, for a length below the floor, and after an aborted field. A design that restarted the phase wrongly, or that counted one bit too many or too few, would move the data_ready strobe or break the pattern.

The bench changes len_bytes in the middle of the field to catch a design that does not latch the length. It drives nonzero NRZ bytes inside the field, in the data phase and in idle, to catch a flag that is not sticky, that is never cleared, or that checks outside the field. The first data bit is sampled on the strobe cycle's edge, so an off-by-one handover shows up as a wrong polarity. After each gate drop the bench checks that the polarity reads zero.

// File: rtl/wpt_pkg.sv
package wpt_pkg;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_SYNC = 2'd1,
      PH_DATA = 2'd2
   } wpt_phase_e;

   typedef enum logic [1:0] {
      TG_HOLD  = 2'd0,
      TG_CLEAR = 2'd1,
      TG_LOAD  = 2'd2,
      TG_FLIP  = 2'd3
   } wpt_tgl_op_e;

endpackage

// File: rtl/wpt_sync_seq.sv
module wpt_sync_seq
   import wpt_pkg::*;
#(
   parameter int LEN_W         = 8,
   parameter int MIN_BYTES     = 8,
   parameter int BITS_PER_BYTE = 9
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             gate,
   input  logic [LEN_W-1:0] len_bytes,
   output wpt_phase_e       phase,
   output logic             start,
   output wpt_tgl_op_e      tgl_op,
   output logic             tgl_val,
   output logic             ready,
   output logic             sync_odd,
   output logic             low_drive
);

   localparam int MAX_BITS = ((2 ** LEN_W) - 1) * BITS_PER_BYTE;
   localparam int MIN_BITS = MIN_BYTES * BITS_PER_BYTE;
   localparam int CNT_W    = $clog2(MAX_BITS + 1);
   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] cnt_nx;
   logic [CNT_W-1:0] len_bits;
   logic [CNT_W-1:0] len_calc;
   logic [LEN_W-1:0] eff_bytes;
   logic             last;

   assign cnt_nx    = cnt + ONE;
   assign last      = (cnt == (len_bits - ONE));
   assign eff_bytes = (len_bytes < LEN_W'(MIN_BYTES)) ? LEN_W'(MIN_BYTES) : len_bytes;
   assign len_calc  = CNT_W'(eff_bytes) * CNT_W'(BITS_PER_BYTE);
   assign start     = gate && (phase == PH_IDLE);
   assign sync_odd  = (phase == PH_SYNC) && cnt[0];

   // Toggle flip-flop control for the coming edge
   always_comb begin
      tgl_op  = TG_HOLD;
      tgl_val = 1'b0;
      if (!gate) begin
         tgl_op = TG_CLEAR;
      end else begin
         case (phase)
            PH_IDLE: begin
               tgl_op  = TG_LOAD;
               tgl_val = 1'b1;
            end
            PH_SYNC: begin
               if (last) begin
                  tgl_op = TG_FLIP;
               end else begin
                  tgl_op  = TG_LOAD;
                  tgl_val = ~cnt_nx[1];
               end
            end
            PH_DATA: tgl_op = TG_FLIP;
            default: tgl_op = TG_HOLD;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase     <= PH_IDLE;
         cnt       <= '0;
         len_bits  <= CNT_W'(MIN_BITS);
         ready     <= 1'b0;
         low_drive <= 1'b1;
      end else begin
         low_drive <= ~gate;
         ready     <= 1'b0;
         if (!gate) begin
            phase <= PH_IDLE;
            cnt   <= '0;
         end else begin
            case (phase)
               PH_IDLE: begin
                  phase    <= PH_SYNC;
                  cnt      <= '0;
                  len_bits <= len_calc;
               end
               PH_SYNC: begin
                  if (last) begin
                     phase <= PH_DATA;
                  end else begin
                     cnt   <= cnt_nx;
                     ready <= (cnt_nx == (len_bits - ONE));
                  end
               end
               default: phase <= phase;
            endcase
         end
      end
   end

   p_ready_single_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> !ready);

   p_ready_in_sync_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      ready |-> (phase == PH_SYNC));

   p_len_floor_r4 : assert property (@(posedge clk) disable iff (!rst_n)
      (phase == PH_SYNC) |-> (len_bits >= CNT_W'(MIN_BITS)));

   p_drive_on_r9 : assert property (@(posedge clk) disable iff (!rst_n)
      gate |=> !low_drive);

   p_gate_off_idle_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !gate |=> (low_drive && phase == PH_IDLE && !ready));

endmodule

// File: rtl/wpt_zero_check.sv
module wpt_zero_check
   import wpt_pkg::*;
#(
   parameter int NRZ_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  wpt_phase_e       phase,
   input  logic             start,
   input  logic [NRZ_W-1:0] nrz_byte,
   output logic             sync_err
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_err <= 1'b0;
      end else if (start) begin
         sync_err <= 1'b0;
      end else if ((phase == PH_SYNC) && (nrz_byte != '0)) begin
         sync_err <= 1'b1;
      end
   end

   p_err_sticky_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      (sync_err && !start) |=> sync_err);

   p_err_clear_r7 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> !sync_err);

endmodule

// File: rtl/wpt_toggle_ff.sv
module wpt_toggle_ff
   import wpt_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  wpt_tgl_op_e op,
   input  logic        load_val,
   input  logic        flip_bit,
   output logic        q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= 1'b0;
      end else begin
         case (op)
            TG_CLEAR: q <= 1'b0;
            TG_LOAD:  q <= load_val;
            TG_FLIP:  q <= q ^ flip_bit;
            default:  q <= q;
         endcase
      end
   end

endmodule

// File: rtl/wr_preamble_toggle.sv
module wr_preamble_toggle
   import wpt_pkg::*;
#(
   parameter int LEN_W         = 8,
   parameter int MIN_BYTES     = 8,
   parameter int BITS_PER_BYTE = 9,
   parameter int NRZ_W         = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_gate,
   input  logic [LEN_W-1:0] len_bytes,
   input  logic [NRZ_W-1:0] nrz_byte,
   input  logic             chan_bit,
   output logic             wr_pol,
   output logic             low_drive,
   output logic             data_ready,
   output logic             sync_err
);

   generate
      if (MIN_BYTES < 1 || MIN_BYTES > (2 ** LEN_W) - 1) begin : g_bad_min
         $error("MIN_BYTES must lie in 1 .. 2**LEN_W-1");
      end
      if (BITS_PER_BYTE < 8) begin : g_bad_bpb
         $error("BITS_PER_BYTE must be at least 8");
      end
      if (LEN_W < 4 || NRZ_W < 1) begin : g_bad_w
         $error("LEN_W must be at least 4 and NRZ_W at least 1");
      end
   endgenerate

   wpt_phase_e  phase;
   wpt_tgl_op_e tgl_op;
   logic        tgl_val;
   logic        start;
   logic        sync_odd;

   wpt_sync_seq #(
      .LEN_W         (LEN_W),
      .MIN_BYTES     (MIN_BYTES),
      .BITS_PER_BYTE (BITS_PER_BYTE)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .gate      (wr_gate),
      .len_bytes (len_bytes),
      .phase     (phase),
      .start     (start),
      .tgl_op    (tgl_op),
      .tgl_val   (tgl_val),
      .ready     (data_ready),
      .sync_odd  (sync_odd),
      .low_drive (low_drive)
   );

   wpt_zero_check #(
      .NRZ_W (NRZ_W)
   ) u_zchk (
      .clk      (clk),
      .rst_n    (rst_n),
      .phase    (phase),
      .start    (start),
      .nrz_byte (nrz_byte),
      .sync_err (sync_err)
   );

   wpt_toggle_ff u_tff (
      .clk      (clk),
      .rst_n    (rst_n),
      .op       (tgl_op),
      .load_val (tgl_val),
      .flip_bit (chan_bit),
      .q        (wr_pol)
   );

   // Second bit of each 2T pair repeats the first
   p_pair_hold_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      sync_odd |-> $stable(wr_pol));

   p_gate_low_zero_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !wr_gate |=> !wr_pol);

   p_first_bit_pos_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      start |=> wr_pol);

endmodule

// File: tb/wr_preamble_toggle_tb.sv
module wr_preamble_toggle_tb;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_gate = 1'b0;
   logic [7:0] len_bytes = 8'd8;
   logic [7:0] nrz_byte = 8'd0;
   logic       chan_bit = 1'b0;
   logic       wr_pol;
   logic       low_drive;
   logic       data_ready;
   logic       sync_err;

   int n_tests = 0;
   int n_fail  = 0;
   logic [15:0] lfsr = 16'hACE1;

   always #(CLK_PERIOD / 2) clk = ~clk;

   wr_preamble_toggle u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_gate    (wr_gate),
      .len_bytes  (len_bytes),
      .nrz_byte   (nrz_byte),
      .chan_bit   (chan_bit),
      .wr_pol     (wr_pol),
      .low_drive  (low_drive),
      .data_ready (data_ready),
      .sync_err   (sync_err)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s at %0t: actual=%0h expected=%0h", req, $time, act, exp);
      end
   endtask

   // Starts a write and walks up to stop_at bits of the sync field.
   // Injects a nonzero NRZ byte at bit index inj (negative: none).
   // Returns positioned in the cycle showing the last walked bit.
   task automatic do_sync(input int len_in, input int inj, input int stop_at, input string len_tag);
      int eff;
      int lim;
      eff = ((len_in < 8) ? 8 : len_in) * 9;
      lim = (stop_at < eff) ? stop_at : eff;
      @(negedge clk);
      len_bytes = 8'(len_in);
      wr_gate   = 1'b1;
      nrz_byte  = 8'd0;
      chan_bit  = 1'b0;
      @(negedge clk);
      len_bytes = 8'hFF; // R3: must not affect the field in progress
      chk("R9 drive on", 32'(low_drive), 32'd0);
      chk("R7 clear at start", 32'(sync_err), 32'd0);
      for (int i = 0; i < lim; i++) begin
         chk("R2 pattern", 32'(wr_pol), 32'(((i >> 1) & 1) == 0));
         chk({len_tag, " R5 ready position"}, 32'(data_ready), 32'(i == eff - 1));
         nrz_byte = (i == inj) ? 8'h40 : 8'h00;
         if (i < lim - 1) @(negedge clk);
      end
   endtask

   // Data phase: starts in the data_ready cycle.
   task automatic do_data(input int nbits);
      logic p;
      p = wr_pol;
      for (int j = 0; j < nbits; j++) begin
         lfsr     = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         chan_bit = lfsr[0];
         nrz_byte = (j == 0) ? 8'h00 : 8'hFF; // R7: ignored in data phase
         @(negedge clk);
         p = p ^ chan_bit;
         chk("R6 toggle", 32'(wr_pol), 32'(p));
         chk("R5 single strobe", 32'(data_ready), 32'd0);
         chk("R9 drive on", 32'(low_drive), 32'd0);
      end
      nrz_byte = 8'h00;
      chan_bit = 1'b0;
   endtask

   task automatic do_stop(input logic exp_err);
      wr_gate  = 1'b0;
      chan_bit = 1'b1;
      @(negedge clk);
      chk("R8 zero after gate drop", 32'(wr_pol), 32'd0);
      chk("R8 ready low", 32'(data_ready), 32'd0);
      chk("R9 low drive", 32'(low_drive), 32'd1);
      nrz_byte = 8'hFF; // R7: ignored while idle
      @(negedge clk);
      chk("R8 idle hold", 32'(wr_pol), 32'd0);
      chk("R7 idle ignore", 32'(sync_err), 32'(exp_err));
      nrz_byte = 8'h00;
      chan_bit = 1'b0;
   endtask

   task automatic t_reset();
      #(CLK_PERIOD * 2 + 2);
      chk("R1 pol in reset", 32'(wr_pol), 32'd0);
      chk("R1 drive in reset", 32'(low_drive), 32'd1);
      chk("R1 ready in reset", 32'(data_ready), 32'd0);
      chk("R1 err in reset", 32'(sync_err), 32'd0);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      @(negedge clk);
      chk("R1 pol after reset", 32'(wr_pol), 32'd0);
      chk("R1 drive after reset", 32'(low_drive), 32'd1);
      chk("R1 err after reset", 32'(sync_err), 32'd0);
   endtask

   task automatic t_normal();
      do_sync(10, -1, 100000, "R3");
      do_data(24);
      chk("R7 no error", 32'(sync_err), 32'd0);
      do_stop(1'b0);
   endtask

   task automatic t_clamp();
      do_sync(3, -1, 100000, "R4");
      do_data(6);
      do_stop(1'b0);
      do_sync(0, -1, 100000, "R4");
      do_data(3);
      do_stop(1'b0);
   endtask

   task automatic t_nrz_err();
      do_sync(8, 20, 100000, "R3");
      do_data(3);
      chk("R7 error set", 32'(sync_err), 32'd1);
      do_stop(1'b1);
      chk("R7 sticky", 32'(sync_err), 32'd1);
      do_sync(9, -1, 100000, "R3");
      chk("R7 cleared by new write", 32'(sync_err), 32'd0);
      do_data(2);
      do_stop(1'b0);
   endtask

   task automatic t_abort();
      do_sync(8, -1, 30, "R3");
      do_stop(1'b0);
      do_sync(8, -1, 100000, "R8 restart");
      do_data(4);
      do_stop(1'b0);
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      t_reset();
      t_normal();
      t_clamp();
      t_nrz_err();
      t_abort();
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule